// File: doc/BRIEF.md
# Handshaked Two-Sample Averaging Filter

This block is a streaming filter with a four-phase request/acknowledge channel on each side. Each time a sample arrives on the input channel, the block produces the mean of that sample and the sample before it on the output channel. It then keeps the new sample as the stored history value. After reset, the stored history value is zero.

Inside, a controller steps through a set of four-phase handshakes, one with each part of the datapath. These parts are a level-sensitive capture stage for the new sample, a level-sensitive stage for the history value, an adder whose completion is signalled a fixed number of clock cycles after it is requested (a matched delay), and an output holding stage. Everything is clocked logic that samples the handshake wires.

The sum is formed one bit wider than the data and shifted right by one with truncation, so the result always fits the data width. Once the sample has been captured, the input acknowledge is raised, so the producer may change its data while the average is still being formed. The history value is replaced only after the output transfer has fully finished.

Top module: `avgf_filter`

## Requirements
- R1: After reset `in_ack` and `out_req` are 0 and the stored history value is 0, so the first result after reset is the first sample shifted right by one.
- R2: Each result equals (x + y) >> 1, where x is the new sample and y is the history value, summed at W+1 bits and truncated. With W=8, 255 and 255 give 255, which shows there is no overflow.
- R3: After each result, the history value becomes the sample just consumed. A run of samples gives the mean of each adjacent pair.
- R4: `in_ack` rises only while `in_req` is 1. It stays 1 for as long as `in_req` stays 1, and it falls only after `in_req` has been sampled 0.
- R5: If `in_data` changes after `in_ack` has risen, the result for the sample already taken does not change.
- R6: `out_data` does not change while `out_req` is 1. `out_req` stays 1 until `out_ack` is 1, and it rises again only once `out_ack` has been seen at 0.
- R7: No new sample is acknowledged while the output transfer of the previous sample is still in progress.
- R8: The history value does not change while the adder request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Input request: in_data is valid |
| in_ack | output | 1 | Input acknowledge: the sample is captured |
| in_data | input | W | Input sample |
| out_req | output | 1 | Output request: out_data is valid |
| out_ack | input | 1 | Output acknowledge from the consumer |
| out_data | output | W | Averaged result |

## Verification
The bench drives the extremes of the data range (0 with 0, and all-ones with all-ones) to catch a sum that is kept to W bits and wraps. A design with that fault would return 127 where 255 is expected.

Right after `in_ack` rises, the bench corrupts `in_data`. A design that leaves the sample stage transparent too long would put that value into the result.

The bench also holds `out_ack` low while a second sample is already offered. A design that accepts that sample early would raise `in_ack` during the stall, and it could also overwrite the history value. A reset in the middle of the stream shows whether the history value really returns to zero.

// File: rtl/avgf_pkg.sv
package avgf_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_XOPEN,
      ST_XCLOSE,
      ST_INACK,
      ST_ADD,
      ST_OLOPEN,
      ST_OLCLOSE,
      ST_ARTZ,
      ST_OREQ,
      ST_ORTZ,
      ST_YOPEN,
      ST_YCLOSE
   } avgf_state_t;

endpackage

// File: rtl/avgf_latch.sv
module avgf_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   output logic         ack,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("avgf_latch: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0;
         q   <= '0;
      end else begin
         ack <= req;
         if (req) q <= d;
      end
   end

endmodule

// File: rtl/avgf_adder.sv
module avgf_adder #(
   parameter int W         = 8,
   parameter int ADD_DELAY = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   output logic         ack,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] mean
);

   localparam int SW = W + 1;
   localparam int CW = (ADD_DELAY > 1) ? $clog2(ADD_DELAY) : 1;

   if (ADD_DELAY < 1) begin : g_bad_delay
      $error("avgf_adder: ADD_DELAY must be at least 1");
   end

   logic [SW-1:0] sum_wide;

   always_comb begin
      sum_wide = {1'b0, a} + {1'b0, b};
      mean     = sum_wide[SW-1:1];
   end

   if (ADD_DELAY == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) ack <= 1'b0;
         else        ack <= req;
      end
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || !req) begin
            cnt <= '0;
            ack <= 1'b0;
         end else if (!ack) begin
            if (cnt == CW'(ADD_DELAY - 1)) ack <= 1'b1;
            else                           cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/avgf_ctrl.sv
module avgf_ctrl
   import avgf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_req,
   output logic in_ack,
   output logic out_req,
   input  logic out_ack,
   output logic x_req,
   input  logic x_ack,
   output logic y_req,
   input  logic y_ack,
   output logic ol_req,
   input  logic ol_ack,
   output logic add_req,
   input  logic add_ack
);

   avgf_state_t state, state_nx;
   logic        in_ack_q;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (in_req && !in_ack_q) state_nx = ST_XOPEN;
         ST_XOPEN:   if (x_ack)    state_nx = ST_XCLOSE;
         ST_XCLOSE:  if (!x_ack)   state_nx = ST_INACK;
         ST_INACK:                 state_nx = ST_ADD;
         ST_ADD:     if (add_ack)  state_nx = ST_OLOPEN;
         ST_OLOPEN:  if (ol_ack)   state_nx = ST_OLCLOSE;
         ST_OLCLOSE: if (!ol_ack)  state_nx = ST_ARTZ;
         ST_ARTZ:    if (!add_ack) state_nx = ST_OREQ;
         ST_OREQ:    if (out_ack)  state_nx = ST_ORTZ;
         ST_ORTZ:    if (!out_ack) state_nx = ST_YOPEN;
         ST_YOPEN:   if (y_ack)    state_nx = ST_YCLOSE;
         ST_YCLOSE:  if (!y_ack)   state_nx = ST_IDLE;
         default:                  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         in_ack_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_INACK) in_ack_q <= 1'b1;
         else if (!in_req)      in_ack_q <= 1'b0;
      end
   end

   always_comb begin
      in_ack  = in_ack_q;
      x_req   = (state == ST_XOPEN);
      add_req = (state == ST_ADD) || (state == ST_OLOPEN) || (state == ST_OLCLOSE);
      ol_req  = (state == ST_OLOPEN);
      out_req = (state == ST_OREQ);
      y_req   = (state == ST_YOPEN);
   end

endmodule

// File: rtl/avgf_filter.sv
module avgf_filter #(
   parameter int W         = 8,
   parameter int ADD_DELAY = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_req,
   output logic         in_ack,
   input  logic [W-1:0] in_data,
   output logic         out_req,
   input  logic         out_ack,
   output logic [W-1:0] out_data
);

   logic         x_req, x_ack, y_req, y_ack, ol_req, ol_ack, add_req, add_ack;
   logic [W-1:0] x_q, y_q, mean;

   avgf_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .in_req(in_req), .in_ack(in_ack),
      .out_req(out_req), .out_ack(out_ack),
      .x_req(x_req), .x_ack(x_ack),
      .y_req(y_req), .y_ack(y_ack),
      .ol_req(ol_req), .ol_ack(ol_ack),
      .add_req(add_req), .add_ack(add_ack)
   );

   avgf_latch #(.W(W)) u_xlat (
      .clk(clk), .rst_n(rst_n), .req(x_req), .ack(x_ack), .d(in_data), .q(x_q)
   );

   avgf_latch #(.W(W)) u_ylat (
      .clk(clk), .rst_n(rst_n), .req(y_req), .ack(y_ack), .d(x_q), .q(y_q)
   );

   avgf_adder #(.W(W), .ADD_DELAY(ADD_DELAY)) u_add (
      .clk(clk), .rst_n(rst_n), .req(add_req), .ack(add_ack),
      .a(x_q), .b(y_q), .mean(mean)
   );

   avgf_latch #(.W(W)) u_olat (
      .clk(clk), .rst_n(rst_n), .req(ol_req), .ack(ol_ack), .d(mean), .q(out_data)
   );

endmodule

// File: rtl/avgf_checker.sv
module avgf_checker #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_req,
   input logic         in_ack,
   input logic         out_req,
   input logic         out_ack,
   input logic [W-1:0] out_data,
   input logic         add_req,
   input logic [W-1:0] y_val
);

   AST_AIN_AFTER_RIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ack) |-> !$past(in_req)); // R4

   AST_AIN_NEEDS_RIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> $past(in_req)); // R4

   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && $past(out_req)) |-> $stable(out_data)); // R6

   AST_ROUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_req) |-> $past(out_ack)); // R6

   AST_ROUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_req) |-> !$past(out_ack)); // R6

   AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      out_req |-> !$rose(in_ack)); // R7

   AST_Y_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (add_req && $past(add_req)) |-> $stable(y_val)); // R8

endmodule

bind avgf_filter avgf_checker #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .in_req(in_req), .in_ack(in_ack),
   .out_req(out_req), .out_ack(out_ack), .out_data(out_data),
   .add_req(add_req), .y_val(y_q)
);

// File: tb/tb_avgf_filter.sv
module tb_avgf_filter;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_req = 1'b0;
   logic         in_ack;
   logic [W-1:0] in_data = '0;
   logic         out_req;
   logic         out_ack = 1'b0;
   logic [W-1:0] out_data;

   int           n_checks = 0;
   int           n_fail = 0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] y_model = '0;
   logic         hold_ack = 1'b0;
   int           n_seen = 0;

   always #5 clk = ~clk;

   avgf_filter #(.W(W), .ADD_DELAY(2)) dut (
      .clk(clk), .rst_n(rst_n),
      .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
      .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] avg(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[W:1];
   endfunction

   // driver: one full input handshake, pushes the expected result
   task automatic send(input logic [W-1:0] x);
      @(negedge clk);
      in_data = x;
      in_req  = 1'b1;
      while (!in_ack) @(negedge clk);
      exp_q.push_back(avg(x, y_model));   // R2, R3
      y_model = x;
      in_data = ~x;                       // R5: corrupt after acknowledge
      repeat (4) @(negedge clk);
      check(in_ack == 1'b1, "R4", int'(in_ack), 1);
      in_req = 1'b0;
      while (in_ack) @(negedge clk);
   endtask

   // monitor: pops expected results as outputs appear
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_req && !out_ack && !hold_ack) begin
            logic [W-1:0] first;
            first = out_data;
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", int'(first), -1);
            end else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               check(first == e, "R2/R3", int'(first), int'(e));
            end
            repeat (2) @(negedge clk);
            check(out_data == first, "R6", int'(out_data), int'(first));
            out_ack = 1'b1;
            while (out_req) @(negedge clk);
            out_ack = 1'b0;
            n_seen++;
         end
      end
   end

   initial begin
      int wd;
      wd = 0;
      while (wd < 100000) begin
         @(negedge clk);
         wd++;
      end
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   task automatic drain(input int target);
      while (n_seen < target) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(in_ack == 1'b0, "R1", int'(in_ack), 0);
      check(out_req == 1'b0, "R1", int'(out_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      send(8'd10);       // R1: history starts at 0 -> 5
      send(8'd20);       // 15
      send(8'd255);      // 137
      send(8'd255);      // R2 overflow boundary -> 255
      send(8'd0);        // 127
      send(8'd0);        // 0
      send(8'd1);        // 0
      send(8'd3);        // 2
      drain(8);

      // R7: stall the output, offer a second sample
      hold_ack = 1'b1;
      send(8'd40);       // captured; output then stalls
      @(negedge clk);
      in_data = 8'd60;
      in_req  = 1'b1;
      repeat (30) @(negedge clk);
      check(in_ack == 1'b0, "R7", int'(in_ack), 0);
      check(out_req == 1'b1, "R6", int'(out_req), 1);
      hold_ack = 1'b0;
      while (!in_ack) @(negedge clk);
      exp_q.push_back(avg(8'd60, y_model));
      y_model = 8'd60;
      in_req = 1'b0;
      while (in_ack) @(negedge clk);
      drain(10);

      // R1: reset mid-stream clears the history value
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(out_req == 1'b0, "R1", int'(out_req), 0);
      rst_n = 1'b1;
      y_model = '0;
      send(8'd100);      // expect 50
      send(8'd7);        // expect 53
      drain(12);
      check(exp_q.size() == 0, "R3", exp_q.size(), 0);

      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule